// File: doc/BRIEF.md
# Two-Stage Integer Controller Core

This block is a small integer processor for control work. It runs fixed 28-bit instructions that it reads from one port of a true dual-port RAM. It keeps its variables behind the other port. Each instruction carries an 8-bit opcode, a 4-bit register index and a 16-bit immediate. The core has sixteen 16-bit working registers, an integer ALU, and an accumulator register that holds the last ALU result so that the next instruction can use it without a memory access.

Both RAM ports return data one cycle after the address is presented. The core therefore fetches one instruction ahead. While one instruction executes, the next one is already on the program port. A prefetch step decodes that next instruction and drives its memory operand address onto the data port, so the operand arrives just as that instruction enters execution. Three things remove the looked-ahead instruction:

- a taken skip, which advances the program counter past it;
- a jump, which reloads the program counter;
- a halt, which freezes the program counter so the final state can be inspected.

The data port also carries stores. When a store executes while the next instruction wants a memory operand, the fetch holds for one cycle.

Top module: `ctlcpu_core`

## Requirements
- R1: An instruction word has its opcode in bits 27:20, the register index r in bits 19:16 and the immediate in bits 15:0. After reset, execution starts at program address 0 and proceeds in address order.
- R2: The opcode's upper nibble selects the ALU function. The codes are 0 add (A+B), 1 subtract (A-B), 2 multiply, 3 AND, 4 OR, 5 NOT of B and 6 move B. Operand A is register r, and the 16-bit result is written to register r.
- R3: Subtraction and addition wrap modulo 2^16, and multiplication keeps only the low 16 bits of the product.
- R4: For ALU opcodes, bits 1:0 pick operand B. The codes are 0 for the immediate, 1 for the data memory word at the immediate address, 2 for the last ALU result, and 3 for the register numbered by immediate bits 3:0.
- R5: The last ALU result is kept unchanged across instructions that are not ALU operations.
- R6: Opcode 0x80 stores register r to the data address given by the immediate. An instruction right after it that reads that address as a memory operand sees the stored value.
- R7: Opcode 0x90 jumps to the program address in the immediate's low bits, and the instruction after the jump is not executed.
- R8: Opcode 0xA0 skips the next instruction when register r is zero. Opcode 0xB0 skips it when register r is non-zero. Otherwise execution continues with the next instruction.
- R9: Opcode 0xF0 halts the core. `halted` goes high, `prog_addr` stays constant, no further stores occur, and no later instruction is executed.
- R10: During reset, `halted` is 0, `data_we` is 0 and `prog_addr` is 0.
- R11: An instruction that reads a register written by the instruction just before it sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | PW | Program port read address |
| prog_rdata | input | 28 | Instruction read from the previous cycle's address |
| data_addr | output | AW | Data port address, used for the prefetch read and for stores |
| data_rdata | input | 16 | Data word read from the previous cycle's address |
| data_we | output | 1 | Data port write enable |
| data_wdata | output | 16 | Data port write value |
| halted | output | 1 | Core has executed a halt |

## Verification
The bench uses four programs.

1. The ALU program puts each function on operand values chosen to expose it. These include a subtraction that borrows through zero, a multiply whose product overflows, and AND/OR masks that differ per bit.
2. The operand program reads from memory, from the accumulator and from other registers. It places a load right after a store to the same address, so a missing fetch hold would return the stale word.
3. The control program takes and falls through both skip forms, and jumps forward over a store. Sentinel words show whether any squashed or post-halt store leaked through.
4. A counted loop uses a backward jump and a skip.

After each program halts, the bench checks that the program address stays frozen and that no store is issued.

// File: rtl/ctlcpu_pkg.sv
package ctlcpu_pkg;

  localparam int OPW = 8;
  localparam int RIW = 4;
  localparam int IMW = 16;
  localparam int IW  = OPW + RIW + IMW;

  localparam logic [3:0] FN_ST   = 4'h8;
  localparam logic [3:0] FN_JMP  = 4'h9;
  localparam logic [3:0] FN_SKZ  = 4'hA;
  localparam logic [3:0] FN_SKNZ = 4'hB;
  localparam logic [3:0] FN_HALT = 4'hF;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_MEM = 2'd1,
    SRC_ACC = 2'd2,
    SRC_REG = 2'd3
  } bsrc_e;

  typedef struct packed {
    logic           alu;
    logic [2:0]     fn;
    bsrc_e          bsrc;
    logic           st;
    logic           jmp;
    logic           skz;
    logic           sknz;
    logic           halt;
    logic [RIW-1:0] ridx;
    logic [IMW-1:0] imm;
  } dec_t;

  function automatic dec_t decode(input logic [IW-1:0] w);
    dec_t d;
    logic [3:0] grp;
    grp    = w[IW-1 -: 4];
    d.alu  = (grp[3] == 1'b0) && (grp != 4'h7);
    d.fn   = grp[2:0];
    d.bsrc = bsrc_e'(w[IW-OPW +: 2]);
    d.st   = (grp == FN_ST);
    d.jmp  = (grp == FN_JMP);
    d.skz  = (grp == FN_SKZ);
    d.sknz = (grp == FN_SKNZ);
    d.halt = (grp == FN_HALT);
    d.ridx = w[IMW +: RIW];
    d.imm  = w[IMW-1:0];
    return d;
  endfunction

endpackage

// File: rtl/ctlcpu_alu.sv
module ctlcpu_alu #(
  parameter int DW = 16
) (
  input  logic [2:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  logic [2*DW-1:0] prod;

  always_comb begin
    prod = a * b;
    case (fn)
      3'd0:    y = a + b;
      3'd1:    y = a - b;
      3'd2:    y = prod[DW-1:0];
      3'd3:    y = a & b;
      3'd4:    y = a | b;
      3'd5:    y = ~b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/ctlcpu_regfile.sv
module ctlcpu_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  output logic [DW-1:0]           rdata_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [DW-1:0]           rdata_b
);

  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/ctlcpu_fetch.sv
module ctlcpu_fetch #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_jmp,
  input  logic [PW-1:0] ex_tgt,
  input  logic          ex_skip,
  input  logic          ex_halt,
  input  logic          stall,
  output logic [PW-1:0] prog_addr,
  output logic          issue,
  output logic          halted
);

  logic [PW-1:0] pc_q, pc_d;
  logic          run_q;
  logic          halt_q, halt_d;

  always_comb begin
    halt_d = halt_q | ex_halt;
    if (!run_q)                        pc_d = '0;
    else if (halt_d || stall)          pc_d = pc_q;
    else if (ex_jmp)                   pc_d = ex_tgt;
    else                               pc_d = pc_q + PW'(1);
    issue = run_q & ~halt_d & ~ex_jmp & ~ex_skip & ~stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      pc_q   <= pc_d;
      halt_q <= halt_d;
    end
  end

  assign prog_addr = pc_d;
  assign halted    = halt_q;

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(prog_addr));

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ex_jmp && !ex_halt && !halt_q) |=> (pc_q == $past(ex_tgt)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stall && !halt_q) |=> $stable(pc_q));

endmodule

// File: rtl/ctlcpu_core.sv
module ctlcpu_core
  import ctlcpu_pkg::*;
#(
  parameter int PW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] prog_addr,
  input  logic [27:0]   prog_rdata,
  output logic [AW-1:0] data_addr,
  input  logic [15:0]   data_rdata,
  output logic          data_we,
  output logic [15:0]   data_wdata,
  output logic          halted
);

  localparam int DW = IMW;
  localparam int RW = $clog2(NREG);

  logic [IW-1:0] ex_ir;
  logic          ex_vld;
  logic          issue;
  dec_t          ex_d, nx_d;
  logic [DW-1:0] ra, rb, opb, alu_y, acc_q;
  logic          alu_wr, st_go, jmp_go, halt_go, skip_go, nx_mem, stall;

  always_comb begin
    ex_d    = decode(ex_ir);
    nx_d    = decode(prog_rdata);
    alu_wr  = ex_vld & ex_d.alu;
    st_go   = ex_vld & ex_d.st;
    jmp_go  = ex_vld & ex_d.jmp;
    halt_go = ex_vld & ex_d.halt;
    skip_go = ex_vld & ((ex_d.skz & (ra == '0)) | (ex_d.sknz & (ra != '0)));
    nx_mem  = nx_d.alu & (nx_d.bsrc == SRC_MEM);
    stall   = st_go & nx_mem;
    case (ex_d.bsrc)
      SRC_IMM: opb = ex_d.imm;
      SRC_MEM: opb = data_rdata;
      SRC_ACC: opb = acc_q;
      default: opb = rb;
    endcase
  end

  ctlcpu_fetch #(.PW(PW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_jmp    (jmp_go),
    .ex_tgt    (ex_d.imm[PW-1:0]),
    .ex_skip   (skip_go),
    .ex_halt   (halt_go),
    .stall     (stall),
    .prog_addr (prog_addr),
    .issue     (issue),
    .halted    (halted)
  );

  ctlcpu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .we      (alu_wr),
    .waddr   (ex_d.ridx[RW-1:0]),
    .wdata   (alu_y),
    .raddr_a (ex_d.ridx[RW-1:0]),
    .rdata_a (ra),
    .raddr_b (ex_d.imm[RW-1:0]),
    .rdata_b (rb)
  );

  ctlcpu_alu #(.DW(DW)) u_alu (
    .fn (ex_d.fn),
    .a  (ra),
    .b  (opb),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    ex_ir <= prog_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= 1'b0;
      acc_q  <= '0;
    end else begin
      ex_vld <= issue;
      if (alu_wr) acc_q <= alu_y;
    end
  end

  assign data_addr  = st_go ? ex_d.imm[AW-1:0] : nx_d.imm[AW-1:0];
  assign data_we    = st_go;
  assign data_wdata = ra;

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_wr |=> $stable(acc_q));

  // R9
  no_store_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !data_we);

  // R8
  skip_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_go |=> !ex_vld);

  // R6
  st_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_vld);

endmodule

// File: tb/sim_ctlcpu_core.sv
`timescale 1ns/1ps
module sim_ctlcpu_core;

  localparam int PW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] prog_addr;
  logic [27:0]   prog_rdata;
  logic [AW-1:0] data_addr;
  logic [15:0]   data_rdata;
  logic          data_we;
  logic [15:0]   data_wdata;
  logic          halted;

  logic [27:0] pmem [256];
  logic [15:0] dmem [256];

  int n_chk = 0;
  int n_bad = 0;
  int post_halt_wr = 0;

  always #2.5 clk = ~clk;

  ctlcpu_core #(.PW(PW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_rdata(prog_rdata),
    .data_addr(data_addr), .data_rdata(data_rdata), .data_we(data_we),
    .data_wdata(data_wdata), .halted(halted)
  );

  always @(posedge clk) begin
    prog_rdata <= pmem[prog_addr];
    data_rdata <= dmem[data_addr];
    if (data_we) dmem[data_addr] <= data_wdata;
  end

  always @(negedge clk) begin
    if (rst_n && halted && data_we) post_halt_wr++;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic put(input int idx, input logic [7:0] op, input logic [3:0] r,
                     input logic [15:0] imm);
    pmem[idx] = {op, r, imm};
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      pmem[i] = {8'hF0, 4'h0, 16'h0000};
      dmem[i] = 16'h0000;
    end
  endtask

  task automatic run_prog(input string name);
    int cyc;
    logic [PW-1:0] pa;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk({name, " R9 halt reached"}, {31'd0, halted}, 32'd1);
    post_halt_wr = 0;
    pa = prog_addr;
    repeat (20) @(negedge clk);
    chk({name, " R9 prog_addr frozen"}, {24'd0, prog_addr}, {24'd0, pa});
    chk({name, " R9 no store after halt"}, post_halt_wr, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 halted in reset", {31'd0, halted}, 32'd0);
    chk("R10 data_we in reset", {31'd0, data_we}, 32'd0);
    chk("R10 prog_addr in reset", {24'd0, prog_addr}, 32'd0);
  endtask

  task automatic t_alu();
    clear_mem();
    put(0,  8'h60, 1, 16'h00FF); put(1,  8'h00, 1, 16'h0001); put(2,  8'h80, 1, 16'h0010);
    put(3,  8'h60, 2, 16'h0005); put(4,  8'h10, 2, 16'h0007); put(5,  8'h80, 2, 16'h0011);
    put(6,  8'h60, 3, 16'h1234); put(7,  8'h20, 3, 16'h0100); put(8,  8'h80, 3, 16'h0012);
    put(9,  8'h60, 4, 16'hF0F0); put(10, 8'h30, 4, 16'h3C3C); put(11, 8'h80, 4, 16'h0013);
    put(12, 8'h60, 5, 16'hF000); put(13, 8'h40, 5, 16'h000F); put(14, 8'h80, 5, 16'h0014);
    put(15, 8'h50, 6, 16'h1234); put(16, 8'h80, 6, 16'h0015);
    run_prog("alu");
    chk("R2 R1 add imm",          {16'd0, dmem[8'h10]}, 32'h0100);
    chk("R3 subtract wraps",      {16'd0, dmem[8'h11]}, 32'hFFFE);
    chk("R3 multiply low half",   {16'd0, dmem[8'h12]}, 32'h3400);
    chk("R2 and",                 {16'd0, dmem[8'h13]}, 32'h3030);
    chk("R2 or",                  {16'd0, dmem[8'h14]}, 32'hF00F);
    chk("R2 not of B",            {16'd0, dmem[8'h15]}, 32'hEDCB);
  endtask

  task automatic t_operands();
    clear_mem();
    dmem[8'h20] = 16'd100;
    dmem[8'h21] = 16'd23;
    put(0,  8'h60, 1, 16'h0000);
    put(1,  8'h01, 1, 16'h0020);
    put(2,  8'h11, 1, 16'h0021);
    put(3,  8'h80, 1, 16'h0030);
    put(4,  8'h01, 1, 16'h0030);
    put(5,  8'h80, 1, 16'h0031);
    put(6,  8'h60, 3, 16'd10);
    put(7,  8'h02, 3, 16'h0000);
    put(8,  8'h22, 3, 16'h0000);
    put(9,  8'h80, 3, 16'h0032);
    put(10, 8'h62, 4, 16'h0000);
    put(11, 8'h80, 4, 16'h0033);
    put(12, 8'h60, 5, 16'd7);
    put(13, 8'h60, 6, 16'd6);
    put(14, 8'h23, 5, 16'h0006);
    put(15, 8'h80, 5, 16'h0034);
    put(16, 8'h03, 5, 16'h0005);
    put(17, 8'h80, 5, 16'h0035);
    run_prog("operands");
    chk("R4 memory operands",            {16'd0, dmem[8'h30]}, 32'd77);
    chk("R6 load after store same addr", {16'd0, dmem[8'h31]}, 32'd154);
    chk("R4 accumulator operand",        {16'd0, dmem[8'h32]}, 32'd400);
    chk("R5 acc held across store",      {16'd0, dmem[8'h33]}, 32'd400);
    chk("R4 register operand",           {16'd0, dmem[8'h34]}, 32'd42);
    chk("R11 back-to-back register",     {16'd0, dmem[8'h35]}, 32'd84);
  endtask

  task automatic t_control();
    clear_mem();
    for (int a = 8'h40; a <= 8'h45; a++) dmem[a] = 16'hAAAA;
    put(0,  8'h60, 1, 16'h0000);
    put(1,  8'hA0, 1, 16'h0000);
    put(2,  8'h80, 1, 16'h0040);
    put(3,  8'h60, 2, 16'h0001);
    put(4,  8'hB0, 2, 16'h0000);
    put(5,  8'h80, 2, 16'h0041);
    put(6,  8'hA0, 2, 16'h0000);
    put(7,  8'h80, 2, 16'h0042);
    put(8,  8'h90, 0, 16'd11);
    put(9,  8'h80, 2, 16'h0043);
    put(10, 8'hF0, 0, 16'h0000);
    put(11, 8'h60, 3, 16'h0055);
    put(12, 8'h80, 3, 16'h0044);
    put(13, 8'hF0, 0, 16'h0000);
    put(14, 8'h80, 3, 16'h0045);
    run_prog("control");
    chk("R8 skip-if-zero taken",       {16'd0, dmem[8'h40]}, 32'hAAAA);
    chk("R8 skip-if-nonzero taken",    {16'd0, dmem[8'h41]}, 32'hAAAA);
    chk("R8 skip-if-zero not taken",   {16'd0, dmem[8'h42]}, 32'h0001);
    chk("R7 jump squashes next",       {16'd0, dmem[8'h43]}, 32'hAAAA);
    chk("R7 jump target executed",     {16'd0, dmem[8'h44]}, 32'h0055);
    chk("R9 no execution after halt",  {16'd0, dmem[8'h45]}, 32'hAAAA);
  endtask

  task automatic t_loop();
    clear_mem();
    put(0, 8'h60, 1, 16'd5);
    put(1, 8'h60, 2, 16'd0);
    put(2, 8'h00, 2, 16'd3);
    put(3, 8'h10, 1, 16'd1);
    put(4, 8'hA0, 1, 16'h0000);
    put(5, 8'h90, 0, 16'd2);
    put(6, 8'h80, 2, 16'h0046);
    run_prog("loop");
    chk("R7 R8 R1 counted loop", {16'd0, dmem[8'h46]}, 32'd15);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_alu();
    t_operands();
    t_control();
    t_loop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule